// File: doc/BRIEF.md
# Command Bus Arbiter

This block chooses, every clock cycle, which of six engine command queues may place its head command on a shared command bus. Each queue presents a valid flag and a 2-bit command class for the command at its head. There are four command classes, and each class goes to its own functional unit. Each unit can raise a stall line to refuse new commands.

Arbitration has two levels. First, any request whose target unit is stalled is removed. Among the requests that remain, the lowest class code wins. Class 0 has the highest priority and class 3 the lowest. Inside the winning class, a round-robin pointer chooses the requester. Each class keeps its own pointer, so the rotation in one class never disturbs another.

The grant is combinational from the current inputs. Pointer updates take effect at the next clock edge. A requester that sees its grant bit high may consider its head command taken in that cycle.

Top module: `cmd_bus_arbiter`

## Requirements
- R1: After reset, every class pointer is zero. With several requesters pending in one class, requester 0 is granted first.
- R2: At most one grant bit is high in any cycle. `grant_valid` is high exactly when a grant bit is high, and `grant_idx` gives the position of that bit.
- R3: When no request is eligible, `grant` is all zeros, `grant_valid` is low and `grant_idx` is 0.
- R4: An eligible request of class c beats every eligible request whose class code is larger than c. Class code 0 is the most urgent.
- R5: Inside one class, after requester i is granted, the search next time starts at requester i+1. It wraps from requester 5 back to requester 0, so every pending requester is served within six grants of its class.
- R6: A class pointer moves only in a cycle in which that class receives a grant. Idle cycles, stalled cycles and cycles won by another class leave it unchanged.
- R7: Each class has its own pointer. A grant in one class does not change the order of service in another class.
- R8: The stall bit at position c of `unit_stall` blocks every request of class c. A request of a lower-priority class may then be granted.
- R9: When a requester's valid flag is low, its class field has no effect on the grant.
- R10: A grant always goes to a requester whose valid flag is high and whose class unit is not stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 6 | Bit i is high when queue i holds a command |
| req_class | input | 12 | Class of requester i in bits [2i+1:2i] |
| unit_stall | input | 4 | Bit c is high when the unit for class c is stalled |
| grant | output | 6 | One-hot grant, or all zeros |
| grant_idx | output | 3 | Index of the granted requester, 0 when there is no grant |
| grant_valid | output | 1 | High when a grant is issued this cycle |

## Verification
`grant`, `grant_idx` and `grant_valid` respond in the same cycle as the inputs, with no register between them. The bench therefore changes the inputs just after a rising edge and compares the outputs at the following falling edge. Pointer movement (R1, R5, R6, R7) appears only in the cycle after a grant. Each such check therefore applies a second stimulus after the next rising edge and reads the new winner at the falling edge of that later cycle. Every scenario starts from a fresh reset, so the expected pointer state can be worked out by hand from the grants issued earlier in that scenario.

// File: rtl/cba_pkg.sv
// Package: shared sizing constants for the command bus arbiter.
// Assumes six requesters and a 2-bit class field giving four classes.
package cba_pkg;
    parameter int NUM_REQ   = 6;
    parameter int CLASS_W   = 2;
    parameter int NUM_CLASS = 1 << CLASS_W;
    parameter int IDX_W     = $clog2(NUM_REQ);
endpackage

// File: rtl/cba_eligibility.sv
// Module: splits requests into one vector per class and drops requests
// whose target unit is stalled. Assumes class c targets unit c.
module cba_eligibility #(
    parameter int NUM_REQ   = cba_pkg::NUM_REQ,
    parameter int CLASS_W   = cba_pkg::CLASS_W,
    parameter int NUM_CLASS = 1 << CLASS_W
) (
    input  logic [NUM_REQ-1:0]                 req_valid,
    input  logic [NUM_REQ*CLASS_W-1:0]         req_class,
    input  logic [NUM_CLASS-1:0]               unit_stall,
    output logic [NUM_CLASS-1:0][NUM_REQ-1:0]  elig
);
    // Build the masked per-class request vectors.
    always_comb begin
        for (int c = 0; c < NUM_CLASS; c++) begin
            for (int i = 0; i < NUM_REQ; i++) begin
                elig[c][i] = req_valid[i] && !unit_stall[c] &&
                             (req_class[i*CLASS_W +: CLASS_W] == CLASS_W'(c));
            end
        end
    end
endmodule

// File: rtl/cba_rr_pick.sv
// Module: round-robin picker for one class with its own pointer.
// The search starts at the pointer and wraps. The pointer moves to one
// past the winner only when upd is high.
module cba_rr_pick #(
    parameter int NUM_REQ = cba_pkg::NUM_REQ,
    parameter int IDX_W   = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req,
    input  logic               upd,
    output logic [IDX_W-1:0]   pick_idx,
    output logic               pick_any
);
    logic [IDX_W-1:0] ptr;

    // Find the first set request at or after the pointer, wrapping.
    always_comb begin
        pick_idx = '0;
        pick_any = 1'b0;
        for (int off = 0; off < NUM_REQ; off++) begin
            int cand;
            cand = int'(ptr) + off;
            if (cand >= NUM_REQ) cand = cand - NUM_REQ;
            if (!pick_any && req[cand]) begin
                pick_any = 1'b1;
                pick_idx = IDX_W'(cand);
            end
        end
    end

    // Move the pointer one past the winner after a grant in this class.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (upd && pick_any)
            ptr <= (pick_idx == IDX_W'(NUM_REQ - 1)) ? '0 : pick_idx + 1'b1;
    end
endmodule

// File: rtl/cba_class_select.sv
// Module: fixed-priority choice among classes. The lowest class code that
// has an eligible request wins.
module cba_class_select #(
    parameter int CLASS_W   = cba_pkg::CLASS_W,
    parameter int NUM_CLASS = 1 << CLASS_W
) (
    input  logic [NUM_CLASS-1:0] class_any,
    output logic [CLASS_W-1:0]   win_class,
    output logic                 win_any
);
    // Scan from least to most urgent so that the most urgent class is assigned last.
    always_comb begin
        win_class = '0;
        win_any   = 1'b0;
        for (int c = NUM_CLASS - 1; c >= 0; c--) begin
            if (class_any[c]) begin
                win_class = CLASS_W'(c);
                win_any   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmd_bus_arbiter.sv
// Module: top of the two-level command bus arbiter. Stalled requests are
// masked first, then class priority is applied, then round-robin within
// the class. The grant is combinational; the pointers are registered.
module cmd_bus_arbiter #(
    parameter int NUM_REQ   = cba_pkg::NUM_REQ,
    parameter int CLASS_W   = cba_pkg::CLASS_W,
    parameter int NUM_CLASS = 1 << CLASS_W,
    parameter int IDX_W     = $clog2(NUM_REQ)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REQ-1:0]         req_valid,
    input  logic [NUM_REQ*CLASS_W-1:0] req_class,
    input  logic [NUM_CLASS-1:0]       unit_stall,
    output logic [NUM_REQ-1:0]         grant,
    output logic [IDX_W-1:0]           grant_idx,
    output logic                       grant_valid
);
    logic [NUM_CLASS-1:0][NUM_REQ-1:0] elig;
    logic [NUM_CLASS-1:0][IDX_W-1:0]   pick_idx;
    logic [NUM_CLASS-1:0]              pick_any;
    logic [CLASS_W-1:0]                win_class;
    logic                              win_any;

    cba_eligibility #(.NUM_REQ(NUM_REQ), .CLASS_W(CLASS_W), .NUM_CLASS(NUM_CLASS)) u_elig (
        .req_valid (req_valid),
        .req_class (req_class),
        .unit_stall(unit_stall),
        .elig      (elig)
    );

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        cba_rr_pick #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_rr (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (elig[c]),
            .upd     (win_any && (win_class == CLASS_W'(c))),
            .pick_idx(pick_idx[c]),
            .pick_any(pick_any[c])
        );
    end

    cba_class_select #(.CLASS_W(CLASS_W), .NUM_CLASS(NUM_CLASS)) u_sel (
        .class_any(pick_any),
        .win_class(win_class),
        .win_any  (win_any)
    );

    // Route the winning class's pick to the outputs.
    always_comb begin
        grant_valid = win_any;
        grant_idx   = win_any ? pick_idx[win_class] : '0;
        for (int i = 0; i < NUM_REQ; i++)
            grant[i] = win_any && (grant_idx == IDX_W'(i));
    end
endmodule

// File: rtl/cba_checker.sv
// Module: properties on the arbiter ports, attached by bind below.
module cba_checker #(
    parameter int NUM_REQ   = cba_pkg::NUM_REQ,
    parameter int CLASS_W   = cba_pkg::CLASS_W,
    parameter int NUM_CLASS = 1 << CLASS_W,
    parameter int IDX_W     = $clog2(NUM_REQ)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_REQ-1:0]         req_valid,
    input logic [NUM_REQ*CLASS_W-1:0] req_class,
    input logic [NUM_CLASS-1:0]       unit_stall,
    input logic [NUM_REQ-1:0]         grant,
    input logic [IDX_W-1:0]           grant_idx,
    input logic                       grant_valid
);
    logic               any_ok;
    logic [CLASS_W-1:0] best;
    logic [CLASS_W-1:0] g_class;

    // Reference view: whether any request is eligible, and the most urgent eligible class.
    always_comb begin
        any_ok = 1'b0;
        best   = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            logic [CLASS_W-1:0] cl;
            cl = req_class[i*CLASS_W +: CLASS_W];
            if (req_valid[i] && !unit_stall[cl]) begin
                if (!any_ok || cl < best) best = cl;
                any_ok = 1'b1;
            end
        end
        g_class = req_class[grant_idx*CLASS_W +: CLASS_W];
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_valid_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (grant != '0));
    p_idx_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant[grant_idx]);
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ok |-> (!grant_valid && grant_idx == '0));
    p_class_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (g_class == best));
    p_no_starve_work_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_ok |-> grant_valid);
    p_grant_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (req_valid[grant_idx] && !unit_stall[g_class]));
endmodule

bind cmd_bus_arbiter cba_checker #(
    .NUM_REQ(NUM_REQ), .CLASS_W(CLASS_W), .NUM_CLASS(NUM_CLASS), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sim_cmd_bus_arbiter.sv
// Bench: directed scenarios, each in its own task, each checking its results.
module sim_cmd_bus_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  req_valid = '0;
    logic [11:0] req_class = '0;
    logic [3:0]  unit_stall = '0;
    logic [5:0]  grant;
    logic [2:0]  grant_idx;
    logic        grant_valid;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    cmd_bus_arbiter u0 (.*);

    // Check the combinational outputs; call only at a falling edge.
    task automatic expect_grant(input bit v, input int idx, input string tag);
        logic [5:0] eg;
        eg = v ? (6'b1 << idx) : 6'b0;
        checks++;
        if (grant_valid !== v || grant !== eg || grant_idx !== (v ? 3'(idx) : 3'd0)) begin
            errors++;
            $display("FAIL %s: got valid=%0b grant=%b idx=%0d, expected valid=%0b grant=%b idx=%0d",
                     tag, grant_valid, grant, grant_idx, v, eg, v ? idx : 0);
        end
    endtask

    // Drive inputs just after the rising edge, then wait for the falling edge.
    task automatic apply(input logic [5:0] v, input logic [11:0] cl, input logic [3:0] st);
        @(posedge clk); #1;
        req_valid = v; req_class = cl; unit_stall = st;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; req_valid = '0; req_class = '0; unit_stall = '0;
        @(posedge clk); @(negedge clk);
        expect_grant(0, 0, "R3 reset state");
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    // Class 2 for every requester: 2'b10 repeated six times.
    localparam logic [11:0] ALL_C2 = 12'b10_10_10_10_10_10;

    task automatic t_reset_and_rotate();
        do_reset();
        apply(6'h3F, ALL_C2, 4'h0);
        expect_grant(1, 0, "R1 first grant after reset");
        for (int k = 1; k <= 6; k++) begin
            apply(6'h3F, ALL_C2, 4'h0);
            expect_grant(1, k % 6, "R5 rotation");
        end
    endtask

    task automatic t_wrap_sparse();
        do_reset();
        apply(6'b010010, ALL_C2, 4'h0);
        expect_grant(1, 1, "R5 sparse first");
        apply(6'b010010, ALL_C2, 4'h0);
        expect_grant(1, 4, "R5 sparse second");
        apply(6'b010010, ALL_C2, 4'h0);
        expect_grant(1, 1, "R5 sparse wrap");
    endtask

    task automatic t_class_priority();
        do_reset();
        // Requester 5 class 0, others class 3.
        apply(6'h3F, 12'b00_11_11_11_11_11, 4'h0);
        expect_grant(1, 5, "R4 class 0 beats class 3");
        // Requester 3 class 1, requester 0 class 3, requester 1 class 2.
        apply(6'b001011, 12'b00_00_01_00_10_11, 4'h0);
        expect_grant(1, 3, "R4 class 1 beats 2 and 3");
    endtask

    task automatic t_stall();
        do_reset();
        // Requester 2 class 0, requester 4 class 1; unit 0 stalled.
        apply(6'b010100, 12'b00_01_00_00_00_00, 4'b0001);
        expect_grant(1, 4, "R8 stalled class skipped");
        apply(6'b010100, 12'b00_01_00_00_00_00, 4'b0011);
        expect_grant(0, 0, "R3 all eligible stalled");
        apply(6'b010100, 12'b00_01_00_00_00_00, 4'b0000);
        expect_grant(1, 2, "R8 stall released");
    endtask

    task automatic t_pointer_hold();
        do_reset();
        apply(6'b000011, ALL_C2, 4'b0100);
        expect_grant(0, 0, "R3 stalled class only");
        apply(6'b000000, ALL_C2, 4'h0);
        expect_grant(0, 0, "R3 no requests");
        apply(6'b000011, ALL_C2, 4'h0);
        expect_grant(1, 0, "R6 pointer held through idle");
        apply(6'b000011, ALL_C2, 4'h0);
        expect_grant(1, 1, "R6 pointer moved after grant");
    endtask

    task automatic t_independent();
        do_reset();
        apply(6'b000011, 12'b00_00_00_00_01_01, 4'h0);
        expect_grant(1, 0, "R7 class 1 first");
        apply(6'b001000, 12'b00_00_00_00_00_00, 4'h0);
        expect_grant(1, 3, "R7 class 0 grant");
        apply(6'b000011, 12'b00_00_00_00_01_01, 4'h0);
        expect_grant(1, 1, "R7 class 1 pointer untouched by class 0");
        apply(6'b001001, 12'b00_00_00_00_00_00, 4'h0);
        expect_grant(1, 0, "R7 class 0 pointer wrapped past 3");
    endtask

    task automatic t_invalid_ignored();
        do_reset();
        // Requesters 0 and 1 carry class 0 but are not valid; requester 4 valid with class 3.
        apply(6'b010000, 12'b00_11_00_00_00_00, 4'h0);
        expect_grant(1, 4, "R9 invalid class ignored");
        apply(6'b000000, 12'b00_00_00_00_00_00, 4'h0);
        expect_grant(0, 0, "R9 invalid only");
    endtask

    initial begin
        t_reset_and_rotate();
        t_wrap_sparse();
        t_class_priority();
        t_stall();
        t_pointer_hold();
        t_independent();
        t_invalid_ignored();
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 5000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule